// File: doc/BRIEF.md
# Virtual-function base address register slot

This block holds one base address register of a virtual-function BAR set inside a single-root I/O virtualization capability. It is built at elaboration time as one of three kinds: a 32-bit memory window, a 64-bit memory window or an I/O window. Two parameters fix the aperture size and the prefetchable flag. Software uses configuration reads and writes to program the window's base address. The low type field cannot be changed. Address bits below the aperture size always read as zero. Because of this, writing all ones and reading the value back tells software the aperture size.

A 64-bit memory window takes two adjacent configuration dwords, and the select input picks one of them. The lower dword carries the type field and address bits 31 up to the aperture boundary. The upper dword carries address bits 63:32. The block's outputs are the combined base address, a flag that is high while that address is non-zero, and a select that tells the downstream decode whether the window is in I/O or memory space.

The aperture size must be a power of two. It must be at least 16 bytes for a memory window and at least 4 bytes for an I/O window, and at most 4 GiB for the 32-bit kinds. Any other value stops elaboration with an error.

Top module: `vf_bar_slot`

## Requirements
- R1: A write to the lower dword keeps only the bits set in ~(aperture - 1) above the type field. A read of that dword returns the kept bits ORed with the fixed type field.
- R2: After all ones are written to every dword, a read returns ~(aperture - 1) for each dword, with the type field in place of the low bits.
- R3: The type field reads as follows and never changes. For a 32-bit memory window, bits 3:0 are {prefetch, 0, 0, 0}. For a 64-bit memory window, bits 3:0 are {prefetch, 1, 0, 0}. For an I/O window, bits 1:0 are 01.
- R4: With the 64-bit kind, select 1 reads and writes bits 63:32 of the single shared address register. With the 32-bit kinds, select 1 reads zero and writes to it change nothing.
- R5: While reset is low, the address bits are zero. After reset, the lower dword reads as the type field alone, the upper dword reads zero, the mapped flag is low and the base output is zero.
- R6: The space select is 1 for the I/O kind and 0 for both memory kinds.
- R7: The mapped flag is high exactly when the combined address is non-zero. While it is high, the base output equals that address, which is aligned to the aperture. While it is low, the base output is zero.
- R8: A write takes effect at the rising clock edge where the write strobe is high. Read data follows the select input without delay. While the strobe is low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_sel | input | 1 | Dword select: 0 lower, 1 upper |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword |
| bar_base | output | 64 | Programmed base address, zero while unmapped |
| bar_is_io | output | 1 | 1 for I/O space, 0 for memory space |
| bar_mapped | output | 1 | Combined address is non-zero |

## Verification
Three instances receive the same write stream: a 1 MiB prefetchable 64-bit memory window, a 4 KiB 32-bit memory window and a 32-byte I/O window. Each of the three has its own mask, type field and dword count. The all-ones probe produces a different sizing pattern for each kind, and it is also checked against fixed constants. Writes of only the type-field bits should leave every window unmapped. An upper-only write should map the 64-bit window and be ignored by the other two. A mid-run reset separates the reset values from the programmed state. Random writes, biased toward all ones and zero, catch mask and merge errors that the directed patterns miss.

// File: rtl/vfbar_pkg.sv
package vfbar_pkg;

  typedef enum logic [1:0] {
    BAR_MEM32 = 2'd0,
    BAR_IO    = 2'd1,
    BAR_MEM64 = 2'd2
  } bar_kind_e;

  // Fixed low field as seen by software.
  function automatic logic [31:0] kind_type_bits(bar_kind_e k, logic pf);
    case (k)
      BAR_MEM64: kind_type_bits = {28'd0, pf, 3'b100};
      BAR_IO:    kind_type_bits = 32'h0000_0001;
      default:   kind_type_bits = {28'd0, pf, 3'b000};
    endcase
  endfunction

  // Bit positions taken by the fixed field.
  function automatic logic [31:0] kind_field_mask(bar_kind_e k);
    kind_field_mask = (k == BAR_IO) ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  function automatic bit is_pow2(logic [63:0] v);
    is_pow2 = (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction

endpackage

// File: rtl/vfbar_dword.sv
module vfbar_dword #(
  parameter logic [31:0] WMASK = 32'hFFFF_F000,
  parameter logic [31:0] FIXED = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val,
  output logic [31:0] addr_q
);

  logic [31:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (wr_en) q_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= '0;
    else if (wr_en) q_q <= q_d;
  end

  assign rd_val = q_q | FIXED;
  assign addr_q = q_q;

  // After a write, every writable bit reads back as written.
  assert_wmask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((rd_val ^ $past(wdata)) & WMASK) == 32'd0));

endmodule

// File: rtl/vfbar_map.sv
module vfbar_map #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base,
  output logic          mapped
);

  always_comb begin
    mapped = |addr;
    base   = mapped ? addr : '0;
  end

endmodule

// File: rtl/vf_bar_slot.sv
module vf_bar_slot #(
  parameter vfbar_pkg::bar_kind_e KIND = vfbar_pkg::BAR_MEM64,
  parameter logic                 PREFETCH = 1'b1,
  parameter logic [63:0]          APERTURE_BYTES = 64'h0000_0000_0010_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_dw_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [63:0] bar_base,
  output logic        bar_is_io,
  output logic        bar_mapped
);
  import vfbar_pkg::*;

  localparam int          NUM_DW   = (KIND == BAR_MEM64) ? 2 : 1;
  localparam logic [63:0] APER_M1  = APERTURE_BYTES - 64'd1;
  localparam logic [63:0] ADDR_MSK = ~APER_M1;
  localparam logic [31:0] TYPE_LO  = kind_type_bits(KIND, PREFETCH);
  localparam logic [31:0] FIELD_LO = kind_field_mask(KIND);
  localparam logic [63:0] MIN_SIZE = (KIND == BAR_IO) ? 64'd4 : 64'd16;

  // Elaboration-time rejection of unusable apertures.
  if (!is_pow2(APERTURE_BYTES)) begin : g_bad_pow2
    $error("vf_bar_slot: aperture size is not a power of two");
  end
  if (APERTURE_BYTES < MIN_SIZE) begin : g_bad_small
    $error("vf_bar_slot: aperture smaller than the type field allows");
  end
  if (NUM_DW == 1 && APERTURE_BYTES > 64'h1_0000_0000) begin : g_bad_big
    $error("vf_bar_slot: aperture exceeds a 32-bit window");
  end

  logic [31:0] dw_rd   [2];
  logic [31:0] dw_addr [2];
  logic [63:0] addr_all;

  for (genvar d = 0; d < 2; d++) begin : g_dw
    if (d < NUM_DW) begin : g_used
      localparam logic [31:0] FIX_D = (d == 0) ? TYPE_LO : 32'd0;
      localparam logic [31:0] WM_D  = (d == 0) ? (ADDR_MSK[31:0] & ~FIELD_LO)
                                               : ADDR_MSK[63:32];
      logic wr_d;
      assign wr_d = cfg_wr && (cfg_dw_sel == 1'(d));
      vfbar_dword #(.WMASK(WM_D), .FIXED(FIX_D)) u_dw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_d),
        .wdata  (cfg_wdata),
        .rd_val (dw_rd[d]),
        .addr_q (dw_addr[d])
      );
    end else begin : g_absent
      assign dw_rd[d]   = 32'd0;
      assign dw_addr[d] = 32'd0;
    end
  end

  assign addr_all  = {dw_addr[1], dw_addr[0]};
  assign cfg_rdata = dw_rd[cfg_dw_sel];
  assign bar_is_io = (KIND == BAR_IO);

  vfbar_map #(.AW(64)) u_map (
    .addr   (addr_all),
    .base   (bar_base),
    .mapped (bar_mapped)
  );

  assert_base_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_base & APER_M1) == 64'd0);

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bar_mapped |-> (bar_base == 64'd0));

  assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(bar_base) && $stable(bar_mapped)));

  assert_type_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dw_sel |-> ((cfg_rdata & FIELD_LO) == TYPE_LO));

  if (NUM_DW == 1) begin : g_chk32
    assert_upper_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dw_sel |-> (cfg_rdata == 32'd0));
  end

endmodule

// File: tb/sim_vf_bar_slot.sv
module sim_vf_bar_slot;
  import vfbar_pkg::*;

  localparam logic [63:0] SZ0 = 64'h10_0000;
  localparam logic [63:0] SZ1 = 64'h1000;
  localparam logic [63:0] SZ2 = 64'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic cfg_dw_sel = 1'b0;
  logic [31:0] cfg_wdata = 32'd0;

  logic [31:0] rd   [3];
  logic [63:0] base [3];
  logic        isio [3];
  logic        mapd [3];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vf_bar_slot #(.KIND(BAR_MEM64), .PREFETCH(1'b1), .APERTURE_BYTES(SZ0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_sel(cfg_dw_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd[0]), .bar_base(base[0]),
    .bar_is_io(isio[0]), .bar_mapped(mapd[0]));
  vf_bar_slot #(.KIND(BAR_MEM32), .PREFETCH(1'b0), .APERTURE_BYTES(SZ1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_sel(cfg_dw_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd[1]), .bar_base(base[1]),
    .bar_is_io(isio[1]), .bar_mapped(mapd[1]));
  vf_bar_slot #(.KIND(BAR_IO), .PREFETCH(1'b0), .APERTURE_BYTES(SZ2)) u2 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_sel(cfg_dw_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd[2]), .bar_base(base[2]),
    .bar_is_io(isio[2]), .bar_mapped(mapd[2]));

  // Reference model
  logic [63:0] m_mask [3];
  logic [31:0] m_type [3];
  logic [31:0] m_fld  [3];
  bit          m_64   [3];
  bit          m_io   [3];
  logic [31:0] m_lo   [3];
  logic [31:0] m_hi   [3];

  function automatic logic [31:0] exp_rd(int i, logic sel);
    if (!sel) return m_lo[i] | m_type[i];
    return m_64[i] ? m_hi[i] : 32'd0;
  endfunction

  function automatic logic [63:0] exp_addr(int i);
    return m_64[i] ? {m_hi[i], m_lo[i]} : {32'd0, m_lo[i]};
  endfunction

  task automatic chk(string req, int i, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s u%0d: actual %h expected %h", req, i, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < 2; s++) begin
      cfg_dw_sel = 1'(s);
      #1;
      for (int i = 0; i < 3; i++)
        chk({req, " R1 R4 R8 readback"}, i, {32'd0, rd[i]}, {32'd0, exp_rd(i, 1'(s))});
    end
    for (int i = 0; i < 3; i++) begin
      logic [63:0] a;
      a = exp_addr(i);
      chk({req, " R7 mapped"}, i, {63'd0, mapd[i]}, {63'd0, a != 64'd0});
      chk({req, " R7 base"}, i, base[i], (a != 64'd0) ? a : 64'd0);
      chk({req, " R6 space"}, i, {63'd0, isio[i]}, {63'd0, m_io[i]});
    end
  endtask

  task automatic do_write(logic sel, logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_dw_sel = sel;
    cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (!sel) m_lo[i] = data & m_mask[i][31:0] & ~m_fld[i];
      else if (m_64[i]) m_hi[i] = data & m_mask[i][63:32];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      m_lo[i] = 32'd0;
      m_hi[i] = 32'd0;
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    m_mask[0] = ~(SZ0 - 64'd1); m_type[0] = 32'hC; m_fld[0] = 32'hF; m_64[0] = 1; m_io[0] = 0;
    m_mask[1] = ~(SZ1 - 64'd1); m_type[1] = 32'h0; m_fld[1] = 32'hF; m_64[1] = 0; m_io[1] = 0;
    m_mask[2] = ~(SZ2 - 64'd1); m_type[2] = 32'h1; m_fld[2] = 32'h3; m_64[2] = 0; m_io[2] = 1;
    for (int i = 0; i < 3; i++) begin
      m_lo[i] = 32'd0;
      m_hi[i] = 32'd0;
    end

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_all("R5 reset state");

    // Sizing probe
    do_write(1'b0, 32'hFFFF_FFFF);
    do_write(1'b1, 32'hFFFF_FFFF);
    check_all("R2 sizing probe");
    cfg_dw_sel = 1'b0;
    #1;
    chk("R2 R3 probe low", 0, {32'd0, rd[0]}, 64'hFFF0_000C);
    chk("R2 R3 probe low", 1, {32'd0, rd[1]}, 64'hFFFF_F000);
    chk("R2 R3 probe low", 2, {32'd0, rd[2]}, 64'hFFFF_FFE1);
    cfg_dw_sel = 1'b1;
    #1;
    chk("R2 R4 probe high", 0, {32'd0, rd[0]}, 64'hFFFF_FFFF);
    chk("R4 upper empty", 1, {32'd0, rd[1]}, 64'd0);

    // Only the type field positions written
    do_write(1'b1, 32'd0);
    do_write(1'b0, 32'h0000_000F);
    check_all("R3 type field write");

    // Upper half only
    do_write(1'b1, 32'h0000_0003);
    check_all("R4 upper only");
    chk("R4 upper maps 64-bit", 0, {63'd0, mapd[0]}, 64'd1);
    chk("R4 upper ignored", 1, {63'd0, mapd[1]}, 64'd0);

    // Strobe low: nothing changes
    @(negedge clk);
    cfg_dw_sel = 1'b0;
    cfg_wdata = 32'hA5A5_A5A5;
    repeat (2) @(negedge clk);
    check_all("R8 strobe low");

    // Reset after programming
    do_write(1'b0, 32'h1234_5678);
    do_reset();
    check_all("R5 reset after program");

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] d;
      case ($urandom % 4)
        0: d = 32'hFFFF_FFFF;
        1: d = 32'd0;
        default: d = $urandom;
      endcase
      do_write(1'($urandom % 2), d);
      check_all("R1 random");
      if (k % 97 == 50) begin
        do_reset();
        check_all("R5 random reset");
      end
    end

    finish_run();
  end

endmodule